// File: doc/BRIEF.md
# Mode-Selectable Redundancy Router

This block steers five equal-width data sources onto seven sinks according to one of four fixed routing patterns, picked by a two-bit mode word. Source 0 is a shared stimulus that feeds the compute modules. Sources 1 to 3 are the results of three redundant compute modules, and source 4 is the output of a majority voter. Sinks 1 to 3 are the inputs of the three modules, sinks 4 to 6 are the voter inputs, and sink 7 is the final system result.

Three modes run a single module, which saves power. The fourth mode runs all three modules and the voter, so that one faulty module is outvoted. A bitwise two-of-three voter computed from sources 1 to 3 is also provided as an output. A system, or a bench, can feed it back into source 4.

The mode word is held in a register that loads only on a clock edge while the load strobe is high. Routing from sources to sinks is combinational from that register. Every sink that the active pattern does not use is driven to zero.

Top module: `redun_route_top`

## Requirements
- R1: When reset is released, the mode register holds code 00, so the routing is the mode-00 pattern.
- R2: On a rising clock edge with `mode_ld` high, the mode register takes `mode_d`. With `mode_ld` low, `mode_d` has no effect on the routing.
- R3: Mode 00: `snk1` = `src0` and `snk7` = `src1`.
- R4: Mode 01: `snk2` = `src0` and `snk7` = `src2`.
- R5: Mode 10: `snk3` = `src0` and `snk7` = `src3`.
- R6: Mode 11: `snk1`, `snk2` and `snk3` each equal `src0`; `snk4` = `src1`, `snk5` = `src2`, `snk6` = `src3` and `snk7` = `src4`.
- R7: In every mode, any sink not named for that mode in R3 to R6 is all zeros.
- R8: Each bit of `vote_o` is 1 exactly when at least two of the same bit of `src1`, `src2` and `src3` are 1.
- R9: In mode 11, with `vote_o` fed back into `src4`, corrupting any single one of `src1`, `src2` or `src3` leaves `snk7` equal to the value the other two agree on.
- R10: A change on any source reaches the sinks within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ld | input | 1 | Load strobe for the mode register |
| mode_d | input | 2 | New mode code (00, 01, 10 single module; 11 triple) |
| src0 | input | DW | Shared stimulus source |
| src1 | input | DW | Result of redundant module 1 |
| src2 | input | DW | Result of redundant module 2 |
| src3 | input | DW | Result of redundant module 3 |
| src4 | input | DW | Voter result |
| vote_o | output | DW | Bitwise majority of src1, src2, src3 |
| snk1 | output | DW | Input of module 1 |
| snk2 | output | DW | Input of module 2 |
| snk3 | output | DW | Input of module 3 |
| snk4 | output | DW | Voter input A |
| snk5 | output | DW | Voter input B |
| snk6 | output | DW | Voter input C |
| snk7 | output | DW | System result |

## Verification
The bench builds the router with DW = 16 instead of the default 8. The stimulus words put different patterns in the upper and lower bytes, so a masking or replication error confined to one byte of the gating shows up. The wider words also let a single test vector carry bit positions where no source bits agree, where two agree and where all three agree, so the voter's per-bit majority is covered in few vectors. A bench-side multiplexer chooses whether `src4` is driven freely or from `vote_o`. This makes both the plain mode-11 fan-out and the single-fault masking reachable.

// File: rtl/rr_pkg.sv
package rr_pkg;

  localparam int unsigned NSRC = 5;
  localparam int unsigned NSNK = 7;

  typedef enum logic [1:0] {
    RM_SOLO_A = 2'b00,
    RM_SOLO_B = 2'b01,
    RM_SOLO_C = 2'b10,
    RM_TRIPLE = 2'b11
  } route_mode_e;

  // Source select mask for sink k (k = 0 is snk1 ... k = 6 is snk7).
  function automatic logic [NSRC-1:0] sink_select(route_mode_e m, int unsigned k);
    logic [NSRC-1:0] s;
    s = '0;
    case (k)
      0: s[0] = (m == RM_SOLO_A) || (m == RM_TRIPLE);
      1: s[0] = (m == RM_SOLO_B) || (m == RM_TRIPLE);
      2: s[0] = (m == RM_SOLO_C) || (m == RM_TRIPLE);
      3: s[1] = (m == RM_TRIPLE);
      4: s[2] = (m == RM_TRIPLE);
      5: s[3] = (m == RM_TRIPLE);
      6: begin
        case (m)
          RM_SOLO_A: s[1] = 1'b1;
          RM_SOLO_B: s[2] = 1'b1;
          RM_SOLO_C: s[3] = 1'b1;
          default:   s[4] = 1'b1;
        endcase
      end
      default: s = '0;
    endcase
    return s;
  endfunction

  // Two-of-three majority of single bits.
  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (b & c) | (a & c);
  endfunction

endpackage

// File: rtl/rr_mode_reg.sv
module rr_mode_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic [1:0]          d,
  output rr_pkg::route_mode_e q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= rr_pkg::RM_SOLO_A;
    end else if (ld) begin
      q <= rr_pkg::route_mode_e'(d);
    end
  end
endmodule

// File: rtl/rr_voter.sv
module rr_voter #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] y
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign y[i] = rr_pkg::maj3(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/rr_sink_mux.sv
module rr_sink_mux #(
  parameter int unsigned DW       = 8,
  parameter int unsigned NSRC     = 5,
  parameter int unsigned SINK_IDX = 0
) (
  input  rr_pkg::route_mode_e        mode,
  input  logic [NSRC-1:0][DW-1:0]    src,
  output logic [DW-1:0]              y
);
  logic [NSRC-1:0] sel;

  assign sel = rr_pkg::sink_select(mode, SINK_IDX);

  always_comb begin
    y = '0;
    for (int j = 0; j < int'(NSRC); j++) begin
      y = y | (src[j] & {DW{sel[j]}});
    end
  end
endmodule

// File: rtl/redun_route_top.sv
module redun_route_top #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic [1:0]    mode_d,
  input  logic [DW-1:0] src0,
  input  logic [DW-1:0] src1,
  input  logic [DW-1:0] src2,
  input  logic [DW-1:0] src3,
  input  logic [DW-1:0] src4,
  output logic [DW-1:0] vote_o,
  output logic [DW-1:0] snk1,
  output logic [DW-1:0] snk2,
  output logic [DW-1:0] snk3,
  output logic [DW-1:0] snk4,
  output logic [DW-1:0] snk5,
  output logic [DW-1:0] snk6,
  output logic [DW-1:0] snk7
);
  localparam int unsigned NSRC = rr_pkg::NSRC;
  localparam int unsigned NSNK = rr_pkg::NSNK;

  rr_pkg::route_mode_e       mode_r;
  logic [NSRC-1:0][DW-1:0]   src_bus;
  logic [NSNK-1:0][DW-1:0]   snk_bus;

  assign src_bus[0] = src0;
  assign src_bus[1] = src1;
  assign src_bus[2] = src2;
  assign src_bus[3] = src3;
  assign src_bus[4] = src4;

  rr_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (mode_ld),
    .d     (mode_d),
    .q     (mode_r)
  );

  for (genvar g = 0; g < NSNK; g++) begin : g_sink
    rr_sink_mux #(
      .DW       (DW),
      .NSRC     (NSRC),
      .SINK_IDX (g)
    ) u_mux (
      .mode (mode_r),
      .src  (src_bus),
      .y    (snk_bus[g])
    );
  end

  rr_voter #(.DW(DW)) u_vote (
    .a (src1),
    .b (src2),
    .c (src3),
    .y (vote_o)
  );

  assign snk1 = snk_bus[0];
  assign snk2 = snk_bus[1];
  assign snk3 = snk_bus[2];
  assign snk4 = snk_bus[3];
  assign snk5 = snk_bus[4];
  assign snk6 = snk_bus[5];
  assign snk7 = snk_bus[6];
endmodule

// File: rtl/redun_route_chk.sv
module redun_route_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_ld,
  input logic [1:0]    mode_d,
  input logic [1:0]    mode_r,
  input logic [DW-1:0] src0,
  input logic [DW-1:0] src1,
  input logic [DW-1:0] src2,
  input logic [DW-1:0] src3,
  input logic [DW-1:0] src4,
  input logic [DW-1:0] vote_o,
  input logic [DW-1:0] snk1,
  input logic [DW-1:0] snk2,
  input logic [DW-1:0] snk3,
  input logic [DW-1:0] snk4,
  input logic [DW-1:0] snk5,
  input logic [DW-1:0] snk6,
  input logic [DW-1:0] snk7
);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ld |=> mode_r == $past(mode_r));

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |=> mode_r == $past(mode_d));

  // R7
  idle_voter_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r != 2'b11) |-> (snk4 == '0 && snk5 == '0 && snk6 == '0));

  // R6
  triple_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == 2'b11) |-> (snk1 == src0 && snk2 == src0 && snk3 == src0 && snk7 == src4));

  // R5
  solo_c_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == 2'b10) |-> (snk3 == src0 && snk7 == src3 && snk1 == '0));

  // R8
  vote_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src1 == src2) |-> vote_o == src1);
endmodule

bind redun_route_top redun_route_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_ld(mode_ld),
  .mode_d (mode_d),
  .mode_r (mode_r),
  .src0   (src0),
  .src1   (src1),
  .src2   (src2),
  .src3   (src3),
  .src4   (src4),
  .vote_o (vote_o),
  .snk1   (snk1),
  .snk2   (snk2),
  .snk3   (snk3),
  .snk4   (snk4),
  .snk5   (snk5),
  .snk6   (snk6),
  .snk7   (snk7)
);

// File: tb/redun_route_top_tb_top.sv
module redun_route_top_tb_top;
  localparam int unsigned DW = 16;

  typedef struct {
    logic [6:0][DW-1:0] snk;
    logic [DW-1:0]      vote;
    string              tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_ld = 1'b0;
  logic [1:0]    mode_d = 2'b00;
  logic [DW-1:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0, s4_drv = '0;
  logic          use_vote = 1'b0;
  logic [DW-1:0] src4_w, vote_w;
  logic [DW-1:0] k1, k2, k3, k4, k5, k6, k7;
  logic [6:0][DW-1:0] got;
  logic [1:0]    cur_mode = 2'b00;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  assign src4_w = use_vote ? vote_w : s4_drv;
  assign got[0] = k1;
  assign got[1] = k2;
  assign got[2] = k3;
  assign got[3] = k4;
  assign got[4] = k5;
  assign got[5] = k6;
  assign got[6] = k7;

  redun_route_top #(.DW(DW)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_ld(mode_ld),
    .mode_d (mode_d),
    .src0   (s0),
    .src1   (s1),
    .src2   (s2),
    .src3   (s3),
    .src4   (src4_w),
    .vote_o (vote_w),
    .snk1   (k1),
    .snk2   (k2),
    .snk3   (k3),
    .snk4   (k4),
    .snk5   (k5),
    .snk6   (k6),
    .snk7   (k7)
  );

  function automatic logic [DW-1:0] bench_vote(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    logic [DW-1:0] r;
    for (int i = 0; i < int'(DW); i++) begin
      int n;
      n = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (n >= 2);
    end
    return r;
  endfunction

  // Driver: apply sources, build the expectation from the requirements, hand it over.
  task automatic drive(input logic [DW-1:0] a0, a1, a2, a3, a4, input string tag);
    exp_t e;
    logic [DW-1:0] v, p4;
    s0 = a0; s1 = a1; s2 = a2; s3 = a3; s4_drv = a4;
    #1;
    v  = bench_vote(a1, a2, a3);
    p4 = use_vote ? v : a4;
    e.snk = '0;
    e.vote = v;
    e.tag = tag;
    case (cur_mode)
      2'b00: begin e.snk[0] = a0; e.snk[6] = a1; end
      2'b01: begin e.snk[1] = a0; e.snk[6] = a2; end
      2'b10: begin e.snk[2] = a0; e.snk[6] = a3; end
      default: begin
        e.snk[0] = a0; e.snk[1] = a0; e.snk[2] = a0;
        e.snk[3] = a1; e.snk[4] = a2; e.snk[5] = a3; e.snk[6] = p4;
      end
    endcase
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    #1;
  endtask

  task automatic load_mode(input logic [1:0] m, input logic strobe);
    @(negedge clk);
    mode_d = m;
    mode_ld = strobe;
    @(negedge clk);
    mode_ld = 1'b0;
    if (strobe) cur_mode = m;
    #1;
  endtask

  // Monitor: pop expectations and compare against the ports.
  initial begin
    forever begin
      exp_t e;
      bit bad;
      wait (exp_q.size() != 0);
      e = exp_q[0];
      bad = 0;
      for (int k = 0; k < 7; k++) begin
        if (got[k] !== e.snk[k]) begin
          bad = 1;
          $display("FAIL %s snk%0d actual=%h expected=%h", e.tag, k + 1, got[k], e.snk[k]);
        end
      end
      if (vote_w !== e.vote) begin
        bad = 1;
        $display("FAIL %s vote_o actual=%h expected=%h", e.tag, vote_w, e.vote);
      end
      checks++;
      if (bad) fails++;
      void'(exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      $display("FAIL watchdog expired actual=running expected=done");
      fails++;
      checks++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 R7: reset pattern is mode 00, unused sinks zero
    drive(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, "R1_reset_R7");
    // R3: mode 00 with byte-distinct words
    drive(16'hA55A, 16'h0FF0, 16'hC3C3, 16'h1234, 16'hFFFF, "R3_solo_a");
    // R2: mode_d without strobe is ignored
    load_mode(2'b11, 1'b0);
    drive(16'h00FF, 16'hFF00, 16'h0F0F, 16'hF0F0, 16'hBEEF, "R2_no_strobe");
    // R4
    load_mode(2'b01, 1'b1);
    drive(16'h1357, 16'h2468, 16'h9ABC, 16'hDEF0, 16'h7777, "R4_solo_b");
    // R10: sources change with no clock edge between
    drive(16'hFFFF, 16'h0001, 16'h8000, 16'h4242, 16'h0000, "R10_comb_R4");
    // R5
    load_mode(2'b10, 1'b1);
    drive(16'h5A5A, 16'h1111, 16'h2222, 16'h3C3C, 16'h9999, "R5_solo_c");
    drive(16'h0000, 16'hFFFF, 16'hFFFF, 16'h8001, 16'hFFFF, "R5_solo_c_b_R7");
    // R6 with independent src4
    load_mode(2'b11, 1'b1);
    drive(16'hC001, 16'hAAAA, 16'h5555, 16'hF00F, 16'h6969, "R6_triple");
    // R8: mixed agreement per bit
    drive(16'h0000, 16'hF0CC, 16'hFF0A, 16'h0FAA, 16'h0000, "R8_vote_mix");
    drive(16'h1234, 16'h0001, 16'h0002, 16'h0004, 16'h0000, "R8_vote_none");
    // R9: voter fed back, single faults
    use_vote = 1'b1;
    drive(16'h7E7E, 16'hA5A5, 16'hA5A5, 16'hA5A5, 16'h0000, "R9_all_agree");
    drive(16'h7E7E, 16'hA5A5, 16'h5A5A, 16'hA5A5, 16'h0000, "R9_fault_m2");
    drive(16'h7E7E, 16'h0000, 16'hA5A5, 16'hA5A5, 16'h0000, "R9_fault_m1");
    drive(16'h7E7E, 16'hA5A5, 16'hA5A5, 16'hFFFF, 16'h0000, "R9_fault_m3");
    use_vote = 1'b0;
    // R2 R7: back to mode 00, voter feeds must clear
    load_mode(2'b00, 1'b1);
    drive(16'h0F0F, 16'hCAFE, 16'h1111, 16'h2222, 16'h3333, "R2_reload_R7");
    // R1: reset mid-run returns to mode 00
    load_mode(2'b11, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    rst_n = 1'b1;
    cur_mode = 2'b00;
    drive(16'h4321, 16'h8765, 16'h1F1F, 16'h2E2E, 16'h3D3D, "R1_rereset");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule